// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 management transactions to an external PHY over a two-wire management link: a clock output (`mdc`) made by dividing the system clock, and a bidirectional data line split into output value, output enable and input sample. A host starts a transaction with a one-cycle `start` strobe, giving a read or write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. `busy` stays high for the whole transaction and `done` pulses once at its end; a read returns its 16-bit result on `rdata`.

A transaction walks a fixed state sequence. From `IDLE`, an accepted strobe moves to `PREAMBLE` when `preamble_en` is high, else straight to `COMMAND`. `PREAMBLE` drives 32 ones and moves to `COMMAND`. `COMMAND` shifts the command word out most significant bit first, 16 bits for a read and 32 for a write. A read then goes to `CAPTURE`, where the line is released for 19 clocks and the data are sampled; a write goes to `TRAILER`, where the line is released for two clocks. Both end in `FINISH`, which lasts one system clock, raises `done`, and returns to `IDLE`.

Each data bit changes on the falling `mdc` edge and stays put while `mdc` is high. Read samples are taken in the last system clock before `mdc` rises. The divider ratio `DIV` is a parameter. It must be even, and must be chosen so that `mdc` stays at or below 2.5 MHz (20 at 50 MHz).

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `done`, `mdc` and `mdio_oe` are all 0, and `mdc` stays low whenever the block is idle.
- R2: While a transaction runs, `mdc` has a period of `DIV` system clocks, high for `DIV/2` of them.
- R3: When `preamble_en` is 1 at the accepted strobe, the first 32 `mdc` cycles drive the line to 1 with the output enabled; when it is 0, no preamble is sent.
- R4: A read sends 16 driven bits, most significant first: 1,1, then 0,1, then 1,0, then PHY address bits 4..0, then register address bits 4..0.
- R5: After the read command, `mdio_oe` is 0 for exactly 19 `mdc` cycles. Of the 19 samples, the first two and the last are discarded, and samples 3 to 18 become `rdata` bits 15 down to 0.
- R6: A write sends 32 driven bits, most significant first: 0,1, then 0,1, then PHY address bits 4..0, register address bits 4..0, 1,0, then write data bits 15..0.
- R7: After the write command, `mdio_oe` is 0 for exactly two further `mdc` cycles.
- R8: `mdio_o` and `mdio_oe` change only while `mdc` is low, and each read sample is taken in the system clock just before `mdc` rises.
- R9: A transaction has exactly (32 if preamble) + 35 `mdc` rising edges for a read and (32 if preamble) + 34 for a write. `done` is then high for one system clock, and `busy` falls with it.
- R10: A `start` strobe while `busy` is high is ignored: the running frame is unchanged and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| preamble_en | input | 1 | Send 32-one preamble before the command |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid from `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The hardest case is showing that the output is released exactly at the turnaround, and that the captured word comes from samples 3 to 18 and not from a neighbouring window. The bench's PHY responder counts `mdc` edges and drives a distinct value in each released cycle: a 1 in the first turnaround slot, a 0 in the second, the register value, then a trailing 1. A one-cycle shift in sampling would therefore corrupt the returned word. Strobes are also injected in the middle of a frame, to show they leave the recorded bit stream unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_COMMAND  = 3'd2,
        ST_CAPTURE  = 3'd3,
        ST_TRAILER  = 3'd4,
        ST_FINISH   = 3'd5
    } mdio_state_e;

    localparam int PRE_LEN   = 32;
    localparam int RD_CMD    = 16;
    localparam int WR_CMD    = 32;
    localparam int RD_RX     = 19;
    localparam int WR_TAIL   = 2;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic sample_tick,
    output logic end_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] cnt;

    assign sample_tick = run && (cnt == CW'(HALF - 1));
    assign end_tick    = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= end_tick ? '0 : cnt + 1'b1;
            if (sample_tick)
                mdc <= 1'b1;
            else if (end_tick)
                mdc <= 1'b0;
        end
    end

    // R8
    sample_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> $rose(mdc));
endmodule

// File: rtl/mdio_txshift.sv
module mdio_txshift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '0;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {sh[W-2:0], 1'b0};
    end

    assign msb = sh[W-1];
endmodule

// File: rtl/mdio_rxshift.sv
module mdio_rxshift #(
    parameter int W    = 19,
    parameter int OUTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            en,
    input  logic            bit_in,
    output logic [OUTW-1:0] word
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '0;
        else if (clear)
            sh <= '0;
        else if (en)
            sh <= {sh[W-2:0], bit_in};
    end

    // drop the final idle sample (bit 0) and the leading turnaround samples
    assign word = sh[OUTW:1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_not_wr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        preamble_en,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int CYC_W = $clog2(PRE_LEN + 1);

    mdio_state_e state, nxt;
    logic [CYC_W-1:0] cyc;
    logic [CYC_W-1:0] phase_len;
    logic             is_rd;
    logic             run;
    logic             sample_tick;
    logic             end_tick;
    logic             last_cyc;
    logic             accept;
    logic             tx_msb;
    logic [WR_CMD-1:0] cmd_word;
    logic [DATA_W-1:0] rx_word;

    assign accept = (state == ST_IDLE) && start;
    assign run    = (state == ST_PREAMBLE) || (state == ST_COMMAND) ||
                    (state == ST_CAPTURE)  || (state == ST_TRAILER);

    // command word, left aligned; a read uses its top 16 bits only
    always_comb begin
        if (rd_not_wr)
            cmd_word = {2'b11, 2'b01, 2'b10, phy_addr, reg_addr, 16'h0000};
        else
            cmd_word = {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
    end

    mdio_clkgen #(.DIV(DIV)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .mdc         (mdc),
        .sample_tick (sample_tick),
        .end_tick    (end_tick)
    );

    mdio_txshift #(.W(WR_CMD)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (cmd_word),
        .shift ((state == ST_COMMAND) && end_tick),
        .msb   (tx_msb)
    );

    mdio_rxshift #(.W(RD_RX), .OUTW(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .en     ((state == ST_CAPTURE) && sample_tick),
        .bit_in (mdio_i),
        .word   (rx_word)
    );

    // length of the current phase in MDC cycles
    always_comb begin
        unique case (state)
            ST_PREAMBLE: phase_len = CYC_W'(PRE_LEN);
            ST_COMMAND:  phase_len = is_rd ? CYC_W'(RD_CMD) : CYC_W'(WR_CMD);
            ST_CAPTURE:  phase_len = CYC_W'(RD_RX);
            ST_TRAILER:  phase_len = CYC_W'(WR_TAIL);
            default:     phase_len = CYC_W'(1);
        endcase
    end

    assign last_cyc = end_tick && (cyc == phase_len - 1'b1);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = preamble_en ? ST_PREAMBLE : ST_COMMAND;
            ST_PREAMBLE: if (last_cyc) nxt = ST_COMMAND;
            ST_COMMAND:  if (last_cyc) nxt = is_rd ? ST_CAPTURE : ST_TRAILER;
            ST_CAPTURE:  if (last_cyc) nxt = ST_FINISH;
            ST_TRAILER:  if (last_cyc) nxt = ST_FINISH;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transaction datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc   <= '0;
            is_rd <= 1'b0;
            rdata <= '0;
        end else begin
            if (accept)
                is_rd <= rd_not_wr;
            if (nxt != state)
                cyc <= '0;
            else if (end_tick)
                cyc <= cyc + 1'b1;
            if ((state == ST_CAPTURE) && last_cyc)
                rdata <= rx_word;
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_COMMAND: begin
                mdio_o  = tx_msb;
                mdio_oe = 1'b1;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end

    // R8
    mdio_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R1
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> (busy && $stable(is_rd)));

    // R5
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> !mdc);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int DIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_not_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        preamble_en = 1'b0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    mdio_master #(.DIV(DIV)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_not_wr(rd_not_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .preamble_en(preamble_en), .busy(busy), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // recording of each MDC rising edge
    logic rec_o  [0:127];
    logic rec_oe [0:127];
    logic exp_o  [0:127];
    logic exp_oe [0:127];
    int   rise_cnt = 0;
    realtime rise_t [0:3];
    realtime fall_t [0:3];
    int   fall_cnt = 0;

    // PHY responder configuration
    logic        resp_rd = 1'b0;
    int          resp_cmd_len = 0;
    logic [15:0] resp_val = '0;

    always @(posedge mdc) begin
        if (rise_cnt < 128) begin
            rec_o[rise_cnt]  = mdio_o;
            rec_oe[rise_cnt] = mdio_oe;
        end
        if (rise_cnt < 4) rise_t[rise_cnt] = $realtime;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        int k;
        if (fall_cnt < 4) fall_t[fall_cnt] = $realtime;
        fall_cnt = fall_cnt + 1;
        k = rise_cnt - resp_cmd_len;
        if (resp_rd && k >= 0 && k < 19) begin
            if (k == 0)       mdio_i = 1'b1;
            else if (k == 1)  mdio_i = 1'b0;
            else if (k == 18) mdio_i = 1'b1;
            else              mdio_i = resp_val[17-k];
        end else begin
            mdio_i = 1'b1;
        end
    end

    function automatic int build_expect(input logic rd, input logic [4:0] pa,
                                        input logic [4:0] ra, input logic [15:0] wd,
                                        input logic pre);
        logic [31:0] cw;
        int n = 0;
        int cl;
        if (rd) begin
            cw = {2'b11, 2'b01, 2'b10, pa, ra, 16'h0000};
            cl = 16;
        end else begin
            cw = {2'b01, 2'b01, pa, ra, 2'b10, wd};
            cl = 32;
        end
        if (pre) for (int i = 0; i < 32; i++) begin
            exp_o[n] = 1'b1; exp_oe[n] = 1'b1; n++;
        end
        for (int i = 0; i < cl; i++) begin
            exp_o[n] = cw[31-i]; exp_oe[n] = 1'b1; n++;
        end
        for (int i = 0; i < (rd ? 19 : 2); i++) begin
            exp_o[n] = 1'b0; exp_oe[n] = 1'b0; n++;
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic pre,
                             input logic [15:0] pval, input bit poke);
        int n;
        int cl;
        int bad;
        int first_bad;
        int pre_bad;
        int guard;
        string req;
        n = build_expect(rd, pa, ra, wd, pre);
        cl = (pre ? 32 : 0) + (rd ? 16 : 32);
        resp_rd = rd; resp_cmd_len = cl; resp_val = pval;
        @(negedge clk);
        rise_cnt = 0; fall_cnt = 0;
        rd_not_wr = rd; phy_addr = pa; reg_addr = ra; wdata = wd; preamble_en = pre;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        guard = 0;
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 300) begin
                rd_not_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
                preamble_en = ~pre; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(done == 1'b1, "R9", "done seen", done, 1);
        check(rise_cnt == n, "R9", "mdc rising edges", rise_cnt, n);
        bad = 0; first_bad = -1; pre_bad = 0;
        for (int i = 0; i < n && i < 128; i++) begin
            if (rec_oe[i] !== exp_oe[i] || (exp_oe[i] && rec_o[i] !== exp_o[i])) begin
                if (pre && i < 32) pre_bad++;
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (pre) check(pre_bad == 0, "R3", "preamble bits", pre_bad, 0);
        if (rd) req = poke ? "R10" : "R4/R5";
        else    req = poke ? "R10" : "R6/R7";
        check(bad == 0, req, "frame bit mismatches (first index in msg)", first_bad, -1);
        if (rd) check(rdata == pval, "R5", "read data", rdata, pval);
        @(negedge clk);
        check(!done && !busy, "R9", "done one cycle then idle", {done, busy}, 0);
        repeat (DIV * 3) @(negedge clk);
        check(!busy && rise_cnt == n, "R10", "no follow-on transaction", rise_cnt, n);
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mdc && !mdio_oe, "R1", "reset outputs",
              {busy, done, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!mdc && !busy, "R1", "idle after reset", {mdc, busy}, 0);

        // directed: read without preamble, distinct value; also timing of MDC (R2)
        run_frame(1'b1, 5'h01, 5'h05, 16'h0000, 1'b0, 16'hA5C3, 1'b0);
        check((rise_t[1] - rise_t[0]) == 8.0 * DIV, "R2", "mdc period ns",
              int'(rise_t[1] - rise_t[0]), 8 * DIV);
        check((fall_t[0] - rise_t[0]) == 4.0 * DIV, "R2", "mdc high time ns",
              int'(fall_t[0] - rise_t[0]), 4 * DIV);
        // R8: setup time from fall to rise equals half period
        check((rise_t[1] - fall_t[0]) == 4.0 * DIV, "R8", "low phase before rise",
              int'(rise_t[1] - fall_t[0]), 4 * DIV);

        // corner data values and addresses
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h10, 5'h01, 16'h0000, 1'b0, 16'h8001, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b1, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h15, 5'h0A, 16'h5AA5, 1'b0, 16'h0000, 1'b0);

        // R10: strobes injected while busy
        run_frame(1'b1, 5'h03, 5'h11, 16'h0000, 1'b0, 16'h1234, 1'b1);
        run_frame(1'b0, 5'h0C, 5'h02, 16'hBEEF, 1'b1, 16'h0000, 1'b1);

        // constrained random mix
        for (int t = 0; t < 16; t++) begin
            logic        r_rd;
            logic [4:0]  r_pa, r_ra;
            logic [15:0] r_wd, r_pv;
            logic        r_pre;
            r_rd  = 1'($urandom());
            r_pa  = 5'($urandom());
            r_ra  = 5'($urandom());
            r_wd  = 16'($urandom());
            r_pv  = 16'($urandom());
            r_pre = ($urandom() % 4) == 0;
            run_frame(r_rd, r_pa, r_ra, r_wd, r_pre, r_pv, ($urandom() % 5) == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule